// File: doc/BRIEF.md
# SPI Latched-Command Register Interface

This block is the slave side of a serial control port. A master sends fixed 32-bit frames over SPI, most significant bit first, while the active-low select is held low. The block collects each frame in a shift register. A frame does nothing on arrival. Its command runs only when the master later pulses a separate active-low latch input, after select has gone high again.

The frame carries an 8-bit opcode in bits [31:24], an 8-bit address in bits [23:16] and 16 bits of data in bits [15:0]. Writes go to a small register file of 16-bit locations:

- a 10-bit actuator state word;
- four 32-bit compare values, each stored as a low half and a high half.

A read command loads the addressed value into an output shift register. The master collects it during the next whole frame. One more frame format sets two mode flags that the actuator sequencer uses downstream. An active-low enable input gates the whole interface.

All four serial inputs are brought into the system clock through flop synchronisers. Edges are detected on the synchronised copies, so the serial clock must run several times slower than the system clock.

Top module: `spi_cmd_regs`

## Requirements
- R1: After reset, the actuator state, all compare values and both mode flags are zero, and `miso` is low.
- R2: A frame with opcode 0x02 and address 0x00, once latched, loads data bits [9:0] into `act_state`. Frame bits are sampled on rising `sclk` edges while `cs_n` is low, most significant bit first.
- R3: A fully shifted frame changes no output until a falling edge on `latch_n` is seen while `cs_n` is high.
- R4: A latched write (opcode 0x02) to address 2+2k stores the data in bits [15:0] of compare value k (`cmp_val[32k+15:32k]`). A latched write to address 3+2k stores it in bits [31:16]. Here k runs from 0 to 3.
- R5: A latched read (opcode 0x01) of a mapped address returns the 16-bit value as the first 16 bits shifted out on `miso` in the next frame, followed by 16 zero bits. The actuator state reads back zero-extended. Compare halves read back as stored.
- R6: A latched read of an unmapped address (0x01, or 0x0A and above) returns all zeros in the next frame.
- R7: Latching a frame whose opcode is neither 0x02 nor 0x01, or a write to an unmapped address, leaves every register unchanged.
- R8: Latching a frame with bits [31:30]=0, bits [27:24]=0x8 and bits [23:0]=0 sets `past_mode` to bit 29 and `inv_mode` to bit 28. A frame that differs in any of those fixed bits leaves both flags unchanged.
- R9: While `en_n` is high, frames and latch pulses have no effect on any register.
- R10: `miso` stays low throughout any frame that does not follow a latched read, and it is cleared when select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_n | input | 1 | Active-low interface enable |
| sclk | input | 1 | Serial clock from the master; idles low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the master |
| latch_n | input | 1 | Active-low strobe that executes the held frame |
| miso | output | 1 | Serial read-back data to the master |
| act_state | output | STATE_W | Actuator state word |
| cmp_val | output | 32*NUM_CMP | Compare values, value k in bits [32k+31:32k] |
| past_mode | output | 1 | Past-state mode flag |
| inv_mode | output | 1 | Invert mode flag |

## Verification
The bench targets a frame that is shifted in but never latched. A design that acted when select rose would update `act_state` at that point. It also covers a read followed by an idle frame: a read-back register that was not cleared at the end of select would echo stale bits into the second frame.

Both halves of every compare value are written with distinct patterns, so a swapped or off-by-one address decode lands data in the wrong lane. Unknown opcodes, a trigger frame with a stray low bit and writes made while disabled are each followed by an output check. Each of those frames is one that a loose decoder would execute.

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs #(
  parameter int NUM_CMP     = 4,
  parameter int STATE_W     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_n,
  input  logic                   sclk,
  input  logic                   cs_n,
  input  logic                   mosi,
  input  logic                   latch_n,
  output logic                   miso,
  output logic [STATE_W-1:0]     act_state,
  output logic [32*NUM_CMP-1:0]  cmp_val,
  output logic                   past_mode,
  output logic                   inv_mode
);
  localparam int FRAME_W = 32;
  localparam int HALF_W  = FRAME_W / 2;
  localparam logic [7:0] OP_WR = 8'h02;
  localparam logic [7:0] OP_RD = 8'h01;
  localparam logic [3:0] SYNC_IDLE = 4'b1010;

  logic [3:0] sync_q [SYNC_STAGES];
  logic [2:0] prev_q;
  logic [3:0] cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_IDLE;
      prev_q <= {SYNC_IDLE[3], SYNC_IDLE[1:0]};
    end else begin
      sync_q[0] <= {latch_n, mosi, cs_n, sclk};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= {cur[3], cur[1:0]};
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];

  logic sclk_rise, sclk_fall, cs_rise, lat_fire;
  assign sclk_rise = !en_n && !cur[1] &&  cur[0] && !prev_q[0];
  assign sclk_fall = !en_n && !cur[1] && !cur[0] &&  prev_q[0];
  assign cs_rise   =  cur[1] && !prev_q[1];
  assign lat_fire  = !en_n &&  cur[1] && !cur[3] && prev_q[2];

  logic [FRAME_W-1:0] frame;
  always_ff @(posedge clk) begin
    if (!rst_n)         frame <= '0;
    else if (sclk_rise) frame <= {frame[FRAME_W-2:0], cur[2]};
  end

  logic [7:0]        op, addr;
  logic [HALF_W-1:0] wdata;
  logic              is_trig, wr_fire, rd_fire;
  assign op      = frame[31:24];
  assign addr    = frame[23:16];
  assign wdata   = frame[15:0];
  assign is_trig = frame[31:30] == 2'b00 && frame[27:24] == 4'h8 && frame[23:0] == 24'h0;
  assign wr_fire = lat_fire && op == OP_WR;
  assign rd_fire = lat_fire && op == OP_RD;

  always_ff @(posedge clk) begin
    if (!rst_n)                        act_state <= '0;
    else if (wr_fire && addr == 8'h00) act_state <= wdata[STATE_W-1:0];
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    logic [FRAME_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              val_q <= '0;
      else if (wr_fire && addr == 8'(2 + 2*g)) val_q[HALF_W-1:0] <= wdata;
      else if (wr_fire && addr == 8'(3 + 2*g)) val_q[FRAME_W-1:HALF_W] <= wdata;
    end
    assign cmp_val[32*g +: 32] = val_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_mode <= 1'b0;
      inv_mode  <= 1'b0;
    end else if (lat_fire && is_trig) begin
      past_mode <= frame[29];
      inv_mode  <= frame[28];
    end
  end

  logic [HALF_W-1:0] rdata;
  always_comb begin
    rdata = '0;
    if (addr == 8'h00) rdata[STATE_W-1:0] = act_state;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (addr == 8'(2 + 2*k)) rdata = cmp_val[32*k +: HALF_W];
      if (addr == 8'(3 + 2*k)) rdata = cmp_val[32*k + HALF_W +: HALF_W];
    end
  end

  logic [FRAME_W-1:0] rb_q;
  always_ff @(posedge clk) begin
    if (!rst_n)         rb_q <= '0;
    else if (rd_fire)   rb_q <= {rdata, {HALF_W{1'b0}}};
    else if (cs_rise)   rb_q <= '0;
    else if (sclk_fall) rb_q <= {rb_q[FRAME_W-2:0], 1'b0};
  end

  assign miso = rb_q[FRAME_W-1];
endmodule

// File: rtl/spi_cmd_regs_chk.sv
module spi_cmd_regs_chk #(
  parameter int NUM_CMP = 4,
  parameter int STATE_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en_n,
  input logic                  lat_fire,
  input logic                  cs_rise,
  input logic [31:0]           frame,
  input logic                  miso,
  input logic [STATE_W-1:0]    act_state,
  input logic [32*NUM_CMP-1:0] cmp_val,
  input logic                  past_mode,
  input logic                  inv_mode
);
  a_r3_hold_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_fire |=> $stable(act_state) && $stable(cmp_val) && $stable(past_mode) && $stable(inv_mode));

  a_r9_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> $stable(act_state) && $stable(cmp_val) && $stable(past_mode) && $stable(inv_mode));

  a_r7_nonwrite_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    lat_fire && frame[31:24] != 8'h02 |=> $stable(act_state) && $stable(cmp_val));

  a_r8_modes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lat_fire && (frame[27:24] != 4'h8 || frame[23:0] != 24'h0) |=> $stable(past_mode) && $stable(inv_mode));

  a_r10_miso_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && !lat_fire |=> !miso);
endmodule

bind spi_cmd_regs spi_cmd_regs_chk #(.NUM_CMP(NUM_CMP), .STATE_W(STATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_n(en_n), .lat_fire(lat_fire), .cs_rise(cs_rise),
  .frame(frame), .miso(miso), .act_state(act_state), .cmp_val(cmp_val),
  .past_mode(past_mode), .inv_mode(inv_mode)
);

// File: tb/spi_cmd_regs_bench.sv
module spi_cmd_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, latch_n = 1'b1;
  logic miso, past_mode, inv_mode;
  logic [9:0] act_state;
  logic [127:0] cmp_val;

  always #10 clk = ~clk;

  spi_cmd_regs u_spi_cmd_regs (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .latch_n(latch_n), .miso(miso), .act_state(act_state), .cmp_val(cmp_val),
    .past_mode(past_mode), .inv_mode(inv_mode)
  );

  int checks = 0, fails = 0;
  logic [31:0] exp_q [$];
  string tag_q [$];
  logic [31:0] rx_last;
  event frame_done;

  logic [9:0]  m_act = '0;
  logic [31:0] m_cmp [4] = '{default: '0};
  logic        m_past = 1'b0, m_inv = 1'b0;
  logic [31:0] m_last = '0, m_pend = '0;
  logic        m_pend_vld = 1'b0;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return {6'b0, m_act};
    if (a >= 8'h02 && a <= 8'h09) return a[0] ? m_cmp[(a-2)/2][31:16] : m_cmp[(a-2)/2][15:0];
    return 16'h0;
  endfunction

  task automatic frame(input logic [31:0] tx);
    logic [31:0] rx;
    exp_q.push_back(m_pend);
    tag_q.push_back(m_pend_vld ? "R5/R6 read-back" : "R10 idle miso");
    cs_n = 1'b0;
    wclk(6);
    for (int i = 31; i >= 0; i--) begin
      mosi = tx[i];
      wclk(6);
      rx[i] = miso;
      sclk = 1'b1;
      wclk(6);
      sclk = 1'b0;
    end
    wclk(6);
    cs_n = 1'b1;
    wclk(6);
    if (!en_n) m_last = tx;
    m_pend = '0;
    m_pend_vld = 1'b0;
    rx_last = rx;
    -> frame_done;
  endtask

  task automatic latch();
    latch_n = 1'b0;
    wclk(6);
    latch_n = 1'b1;
    wclk(10);
    if (!en_n) begin
      if (m_last[31:24] == 8'h02) begin
        if (m_last[23:16] == 8'h00) m_act = m_last[9:0];
        else if (m_last[23:16] >= 8'h02 && m_last[23:16] <= 8'h09) begin
          if (m_last[16]) m_cmp[(m_last[23:16]-2)/2][31:16] = m_last[15:0];
          else            m_cmp[(m_last[23:16]-2)/2][15:0]  = m_last[15:0];
        end
      end else if (m_last[31:24] == 8'h01) begin
        m_pend = {m_read(m_last[23:16]), 16'h0};
        m_pend_vld = 1'b1;
      end else if (m_last[31:30] == 2'b00 && m_last[27:24] == 4'h8 && m_last[23:0] == 24'h0) begin
        m_past = m_last[29];
        m_inv  = m_last[28];
      end
    end
  endtask

  always @(frame_done) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (rx_last !== e) begin
      fails++;
      $display("FAIL %s: miso stream got %h expected %h", t, rx_last, e);
    end
  end

  task automatic check_out(input string tag);
    checks++;
    if (act_state !== m_act || cmp_val !== {m_cmp[3], m_cmp[2], m_cmp[1], m_cmp[0]} ||
        past_mode !== m_past || inv_mode !== m_inv) begin
      fails++;
      $display("FAIL %s: got act=%h cmp=%h past=%b inv=%b expected act=%h cmp=%h past=%b inv=%b",
               tag, act_state, cmp_val, past_mode, inv_mode,
               m_act, {m_cmp[3], m_cmp[2], m_cmp[1], m_cmp[0]}, m_past, m_inv);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    check_out("R1 reset state");
    checks++;
    if (miso !== 1'b0) begin fails++; $display("FAIL R1: miso got %b expected 0", miso); end

    frame({8'h02, 8'h00, 16'h02A5});
    check_out("R3 no latch yet");
    latch();
    check_out("R2 act write");

    for (int a = 2; a <= 9; a++) begin
      frame({8'h02, 8'(a), 16'(16'h1111 * a + 16'h0F00)});
      latch();
    end
    check_out("R4 compare halves");

    frame({8'h01, 8'h00, 16'h0});
    latch();
    frame(32'h0);
    frame(32'h0);
    frame({8'h01, 8'h07, 16'hFFFF});
    latch();
    frame({8'h01, 8'h03, 16'h0});
    latch();
    frame(32'h0);

    frame({8'h01, 8'h01, 16'h0});
    latch();
    frame({8'h01, 8'h0A, 16'h0});
    latch();
    frame({8'h01, 8'hFF, 16'h0});
    latch();
    frame(32'h0);

    frame({8'h03, 8'h00, 16'h0155});
    latch();
    check_out("R7 unknown opcode");
    frame({8'h02, 8'h01, 16'hBEEF});
    latch();
    check_out("R7 unmapped write");
    frame({8'h02, 8'h0A, 16'hBEEF});
    latch();
    check_out("R7 unmapped write high");

    frame({2'b00, 1'b1, 1'b0, 4'h8, 24'h0});
    latch();
    check_out("R8 past flag");
    frame({2'b00, 1'b0, 1'b1, 4'h8, 24'h0});
    latch();
    check_out("R8 invert flag");
    frame({2'b00, 1'b1, 1'b0, 4'h8, 24'h000001});
    latch();
    check_out("R8 malformed trigger");

    en_n = 1'b1;
    wclk(4);
    frame({8'h02, 8'h00, 16'h00F0});
    latch();
    check_out("R9 disabled write");
    en_n = 1'b0;
    wclk(4);
    frame({8'h01, 8'h00, 16'h0});
    latch();
    frame(32'h0);
    wclk(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule